// File: doc/BRIEF.md
# Dual-Controller Watchdog Ownership Arbiter

Two redundant controllers run the same job side by side, but only one of them may drive a shared output register at any time. Each controller has its own retriggerable watchdog timer in this block. A controller proves that it is alive in two steps. First it pulses a set of checkpoint inputs as its program passes fixed points. Then it issues a kick. The kick restarts the timer only once every checkpoint has been seen since the last accepted kick.

When a timer runs out, that side is marked failed and stays failed until the block is reset. If the failed side owned the output, ownership moves to the healthy standby side on the same clock edge, with no operator action. The enable is a register, so no cycle ever has both sides enabled. Status lights (healthy, failed, in control) and a per-side "peer failed" flag let each controller annunciate a fault of the other side. A manual break input freezes both timers so that manual checks can be made without a timeout.

Top module: `dual_wdog_arbiter`

## Requirements
- R1: While `rst_n` is low, the outputs are: `out_en_o`=2'b01 (side A owns), `led_green_o`=2'b11, `led_red_o`=2'b00, `led_yellow_o`=2'b01, `out_q_o`=0 and both peer flags 0. In every two-bit output, bit 0 is side A and bit 1 is side B.
- R2: Each checkpoint bit is sticky once pulsed. A kick is accepted only when all NUM_CKPT sticky bits of that side are set. An accepted kick restarts that side's timer and clears all of its sticky bits together. A kick without the full set has no effect.
- R3: A healthy side whose timer is not restarted, and not frozen by R4, becomes failed on the TIMEOUT-th counting clock edge after reset or after its last accepted kick. A kick accepted in the last cycle before expiry prevents the failure.
- R4: While `hold_i` is high, neither timer advances, so no side can fail. Counting resumes from the held value when `hold_i` goes low.
- R5: A failed side stays failed until `rst_n` is asserted, whatever kicks and checkpoints it issues.
- R6: At most one bit of `out_en_o` is ever set, and only for a healthy side. When the owner fails while the other side is healthy, ownership passes to the other side on the same edge. When the standby fails, ownership does not change. When both have failed, no side is enabled.
- R7: `out_q_o` loads `wr_data_a_i` or `wr_data_b_i` on a clock edge only when that side's write enable is high and its `out_en_o` bit is set in the cycle before the edge. A write from a side that is not enabled leaves the register unchanged.
- R8: `led_red_o` shows the failed state of each side. `led_green_o` is its inverse. `led_yellow_o` equals `out_en_o`.
- R9: `peer_fail_a_o` is high exactly when side B has failed. `peer_fail_b_o` is high exactly when side A has failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | Manual break: freezes both timers |
| ckpt_a_i | input | NUM_CKPT | Checkpoint pulses, side A |
| ckpt_b_i | input | NUM_CKPT | Checkpoint pulses, side B |
| kick_a_i | input | 1 | Watchdog kick, side A |
| kick_b_i | input | 1 | Watchdog kick, side B |
| wr_en_a_i | input | 1 | Write request to shared register, side A |
| wr_data_a_i | input | OUT_W | Write data, side A |
| wr_en_b_i | input | 1 | Write request to shared register, side B |
| wr_data_b_i | input | OUT_W | Write data, side B |
| out_q_o | output | OUT_W | Shared output register |
| out_en_o | output | 2 | Write enable select per side |
| led_green_o | output | 2 | Healthy indicator per side |
| led_red_o | output | 2 | Failed indicator per side |
| led_yellow_o | output | 2 | In-control indicator per side |
| peer_fail_a_o | output | 1 | Tells side A that side B failed |
| peer_fail_b_o | output | 1 | Tells side B that side A failed |

## Verification
Two events can fall on the same edge. One is the owner's timer expiring while both sides hold write requests, so the handover and a register write coincide. The other is a kick arriving in the very cycle the timer would expire. The bench runs both sides writing distinct data on every cycle through a takeover: the last write before the edge must come from the old owner, and later ones only from the new owner. It also steps the reference model until a timer sits one count from expiry and kicks there, expecting no failure and then a failure exactly TIMEOUT edges later.

// File: rtl/wdarb_pkg.sv
package wdarb_pkg;

   typedef enum logic {
      SIDE_A = 1'b0,
      SIDE_B = 1'b1
   } side_e;

   function automatic logic [1:0] side_onehot(side_e s);
      return (s == SIDE_B) ? 2'b10 : 2'b01;
   endfunction

endpackage

// File: rtl/wdarb_timer.sv
module wdarb_timer #(
   parameter int unsigned NUM_CKPT = 4,
   parameter int unsigned TIMEOUT  = 1000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_i,
   input  logic [NUM_CKPT-1:0] ckpt_i,
   input  logic                kick_i,
   output logic                fail_nxt_o,
   output logic                fail_q_o
);

   localparam int unsigned CNT_W = $clog2(TIMEOUT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [NUM_CKPT-1:0] seen_q, seen_d;
   logic [CNT_W-1:0]    cnt_q, cnt_d;
   logic                fail_q, fail_d;
   logic                accept;

   always_comb begin
      accept = kick_i & (&seen_q) & ~fail_q;
      seen_d = accept ? '0 : (seen_q | ckpt_i);
      cnt_d  = cnt_q;
      fail_d = fail_q;
      if (!fail_q) begin
         if (accept) begin
            cnt_d = '0;
         end else if (!hold_i) begin
            if (cnt_q == LAST) fail_d = 1'b1;
            else               cnt_d  = cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         cnt_q  <= '0;
         fail_q <= 1'b0;
      end else begin
         seen_q <= seen_d;
         cnt_q  <= cnt_d;
         fail_q <= fail_d;
      end
   end

   assign fail_nxt_o = fail_d;
   assign fail_q_o   = fail_q;

endmodule

// File: rtl/wdarb_owner.sv
module wdarb_owner
   import wdarb_pkg::*;
#(
   parameter bit PRIMARY = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] fail_nxt_i,
   output logic [1:0] en_o
);

   localparam side_e FIRST = side_e'(PRIMARY);

   side_e      own_q, own_d;
   logic [1:0] en_q, en_d;

   always_comb begin
      own_d = own_q;
      if (fail_nxt_i[own_q] && !fail_nxt_i[~own_q])
         own_d = side_e'(~own_q);
      en_d = fail_nxt_i[own_d] ? 2'b00 : side_onehot(own_d);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= FIRST;
         en_q  <= side_onehot(FIRST);
      end else begin
         own_q <= own_d;
         en_q  <= en_d;
      end
   end

   assign en_o = en_q;

endmodule

// File: rtl/wdarb_outreg.sv
module wdarb_outreg #(
   parameter int unsigned OUT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 en_i,
   input  logic [1:0]                 we_i,
   input  logic [1:0][OUT_W-1:0]      data_i,
   output logic [OUT_W-1:0]           q_o
);

   logic [1:0] hit;
   assign hit = en_i & we_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q_o <= '0;
      else if (hit[0]) q_o <= data_i[0];
      else if (hit[1]) q_o <= data_i[1];
   end

endmodule

// File: rtl/dual_wdog_arbiter.sv
module dual_wdog_arbiter #(
   parameter int unsigned NUM_CKPT = 4,
   parameter int unsigned TIMEOUT  = 1000,
   parameter int unsigned OUT_W    = 16,
   parameter bit          PRIMARY  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hold_i,
   input  logic [NUM_CKPT-1:0] ckpt_a_i,
   input  logic [NUM_CKPT-1:0] ckpt_b_i,
   input  logic                kick_a_i,
   input  logic                kick_b_i,
   input  logic                wr_en_a_i,
   input  logic [OUT_W-1:0]    wr_data_a_i,
   input  logic                wr_en_b_i,
   input  logic [OUT_W-1:0]    wr_data_b_i,
   output logic [OUT_W-1:0]    out_q_o,
   output logic [1:0]          out_en_o,
   output logic [1:0]          led_green_o,
   output logic [1:0]          led_red_o,
   output logic [1:0]          led_yellow_o,
   output logic                peer_fail_a_o,
   output logic                peer_fail_b_o
);

   localparam int unsigned SIDES = 2;

   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("TIMEOUT must be at least 2");
   end
   if (NUM_CKPT < 1) begin : g_bad_ckpt
      $error("NUM_CKPT must be at least 1");
   end
   if (OUT_W < 1) begin : g_bad_width
      $error("OUT_W must be at least 1");
   end

   logic [SIDES-1:0][NUM_CKPT-1:0] ckpt;
   logic [SIDES-1:0]               kick;
   logic [SIDES-1:0]               fail_nxt, fail_q;
   logic [SIDES-1:0][OUT_W-1:0]    wdata;
   logic [SIDES-1:0]               wen;

   assign ckpt  = {ckpt_b_i, ckpt_a_i};
   assign kick  = {kick_b_i, kick_a_i};
   assign wdata = {wr_data_b_i, wr_data_a_i};
   assign wen   = {wr_en_b_i, wr_en_a_i};

   for (genvar s = 0; s < SIDES; s++) begin : g_side
      wdarb_timer #(
         .NUM_CKPT (NUM_CKPT),
         .TIMEOUT  (TIMEOUT)
      ) u_timer (
         .clk        (clk),
         .rst_n      (rst_n),
         .hold_i     (hold_i),
         .ckpt_i     (ckpt[s]),
         .kick_i     (kick[s]),
         .fail_nxt_o (fail_nxt[s]),
         .fail_q_o   (fail_q[s])
      );
   end

   wdarb_owner #(
      .PRIMARY (PRIMARY)
   ) u_owner (
      .clk        (clk),
      .rst_n      (rst_n),
      .fail_nxt_i (fail_nxt),
      .en_o       (out_en_o)
   );

   wdarb_outreg #(
      .OUT_W (OUT_W)
   ) u_outreg (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (out_en_o),
      .we_i   (wen),
      .data_i (wdata),
      .q_o    (out_q_o)
   );

   assign led_red_o     = fail_q;
   assign led_green_o   = ~fail_q;
   assign led_yellow_o  = out_en_o;
   assign peer_fail_a_o = fail_q[1];
   assign peer_fail_b_o = fail_q[0];

endmodule

// File: rtl/dual_wdog_arbiter_chk.sv
module dual_wdog_arbiter_chk #(
   parameter int unsigned OUT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             hold_i,
   input logic             wr_en_a_i,
   input logic             wr_en_b_i,
   input logic [OUT_W-1:0] out_q_o,
   input logic [1:0]       out_en_o,
   input logic [1:0]       led_red_o,
   input logic [1:0]       led_green_o
);

   a_r6_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_en_o));

   a_r6_enable_healthy_a: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_o[0] |-> !led_red_o[0]);

   a_r6_enable_healthy_b: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_o[1] |-> !led_red_o[1]);

   a_r6_takeover_b: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(led_red_o[0]) && !led_red_o[1]) |-> out_en_o[1]);

   a_r6_takeover_a: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(led_red_o[1]) && !led_red_o[0]) |-> out_en_o[0]);

   a_r5_sticky_a: assert property (@(posedge clk) disable iff (!rst_n)
      led_red_o[0] |=> led_red_o[0]);

   a_r5_sticky_b: assert property (@(posedge clk) disable iff (!rst_n)
      led_red_o[1] |=> led_red_o[1]);

   a_r4_hold_no_new_fail: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(led_red_o));

   a_r7_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (!(out_en_o[0] && wr_en_a_i) && !(out_en_o[1] && wr_en_b_i)) |=> $stable(out_q_o));

   a_r8_green_red: assert property (@(posedge clk) disable iff (!rst_n)
      led_green_o == ~led_red_o);

endmodule

bind dual_wdog_arbiter dual_wdog_arbiter_chk #(.OUT_W(OUT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .hold_i      (hold_i),
   .wr_en_a_i   (wr_en_a_i),
   .wr_en_b_i   (wr_en_b_i),
   .out_q_o     (out_q_o),
   .out_en_o    (out_en_o),
   .led_red_o   (led_red_o),
   .led_green_o (led_green_o)
);

// File: tb/dual_wdog_arbiter_bench.sv
module dual_wdog_arbiter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NC = 3;
   localparam int TO = 12;
   localparam int W  = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold = 1'b0;
   logic [NC-1:0] ck_a = '0, ck_b = '0;
   logic ka = 1'b0, kb = 1'b0, wea = 1'b0, web = 1'b0;
   logic [W-1:0] da = '0, db = '0;

   logic [W-1:0] q;
   logic [1:0] en, grn, red, yel;
   logic pfa, pfb;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_wdog_arbiter #(.NUM_CKPT(NC), .TIMEOUT(TO), .OUT_W(W), .PRIMARY(1'b0)) u_dual_wdog_arbiter (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .ckpt_a_i(ck_a), .ckpt_b_i(ck_b), .kick_a_i(ka), .kick_b_i(kb),
      .wr_en_a_i(wea), .wr_data_a_i(da), .wr_en_b_i(web), .wr_data_b_i(db),
      .out_q_o(q), .out_en_o(en), .led_green_o(grn), .led_red_o(red),
      .led_yellow_o(yel), .peer_fail_a_o(pfa), .peer_fail_b_o(pfb));

   typedef struct {
      logic [1:0]   sel;
      logic [1:0]   bad;
      logic [W-1:0] dat;
      string        tag;
   } exp_t;

   exp_t sb[$];
   int nchk = 0, nfail = 0;
   string tag = "R1";

   // reference state, built from the requirements
   logic [NC-1:0] mseen [2];
   int            mcnt  [2];
   logic [1:0]    mbad;
   logic          mown;
   logic [1:0]    msel;
   logic [W-1:0]  mq;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s (%s) act=%0h exp=%0h", req, tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin mseen[i] = '0; mcnt[i] = 0; end
      mbad = 2'b00; mown = 1'b0; msel = 2'b01; mq = '0;
   endtask

   task automatic tick();
      logic [NC-1:0] ck [2];
      logic k [2];
      logic acc;
      exp_t e;
      ck[0] = ck_a; ck[1] = ck_b; k[0] = ka; k[1] = kb;
      if (wea && msel[0]) mq = da;
      else if (web && msel[1]) mq = db;
      for (int i = 0; i < 2; i++) begin
         acc = k[i] && (&mseen[i]) && !mbad[i];
         mseen[i] = acc ? '0 : (mseen[i] | ck[i]);
         if (!mbad[i]) begin
            if (acc) mcnt[i] = 0;
            else if (!hold) begin
               if (mcnt[i] == TO-1) mbad[i] = 1'b1;
               else mcnt[i]++;
            end
         end
      end
      if (mbad[mown] && !mbad[~mown]) mown = ~mown;
      msel = mbad[mown] ? 2'b00 : (mown ? 2'b10 : 2'b01);
      e.sel = msel; e.bad = mbad; e.dat = mq; e.tag = tag;
      @(posedge clk);
      sb.push_back(e);
      #1;
   endtask

   // monitor: compares each pushed item at the falling edge after its clock edge
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk("R6", {30'd0, en}, {30'd0, e.sel});
         chk("R3", {30'd0, red}, {30'd0, e.bad});
         chk("R8", {28'd0, grn, yel}, {28'd0, ~e.bad, e.sel});
         chk("R9", {30'd0, pfa, pfb}, {30'd0, e.bad[1], e.bad[0]});
         chk("R7", {24'd0, q}, {24'd0, e.dat});
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; hold = 1'b0; ck_a = '0; ck_b = '0;
      ka = 1'b0; kb = 1'b0; wea = 1'b0; web = 1'b0;
      @(posedge clk); @(negedge clk);
      tag = "R1";
      chk("R1", {22'd0, en, grn, red, yel, pfa, pfb}, {22'd0, 2'b01, 2'b11, 2'b00, 2'b01, 1'b0, 1'b0});
      chk("R1", {24'd0, q}, 32'd0);
      model_reset();
      rst_n = 1'b1;
   endtask

   // mode: 0 silent, 1 full checkpoints + kick, 2 partial checkpoints + kick
   task automatic feed(int n, int ma, int mb);
      for (int i = 0; i < n; i++) begin
         ck_a = '0; ck_b = '0; ka = 1'b0; kb = 1'b0;
         if (i % 4 == 0) begin
            ck_a = (ma == 1) ? '1 : (ma == 2) ? NC'(3) : '0;
            ck_b = (mb == 1) ? '1 : (mb == 2) ? NC'(3) : '0;
         end
         if (i % 4 == 1) begin
            ka = (ma != 0); kb = (mb != 0);
         end
         wea = 1'b1; web = 1'b1;
         da = W'(i + 8'h10); db = W'(8'hF0 - i);
         tick();
      end
      wea = 1'b0; web = 1'b0; ck_a = '0; ck_b = '0; ka = 1'b0; kb = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      model_reset();
      do_reset();

      // both healthy, only A's writes land
      tag = "R2"; feed(40, 1, 1);
      // B supplies only part of its checkpoints: standby fails, A keeps control
      tag = "R2"; feed(30, 1, 2);
      // failed B kicks correctly but stays failed
      tag = "R5"; feed(20, 1, 1);

      // owner A goes silent while both write each cycle: takeover by B
      do_reset();
      tag = "R6"; feed(30, 0, 1);
      tag = "R7"; feed(10, 1, 1);

      // manual break freezes timers, then both expire: nobody enabled
      do_reset();
      tag = "R4"; hold = 1'b1; feed(40, 0, 0);
      hold = 1'b0; feed(20, 0, 0);

      // kick on the last cycle before expiry rescues, then exact expiry
      do_reset();
      tag = "R3";
      ck_a = '1; ck_b = '1; tick();
      ck_a = '0; ck_b = '0;
      while (mcnt[0] != TO-1) tick();
      ka = 1'b1; kb = 1'b1; tick();
      ka = 1'b0; kb = 1'b0;
      for (int i = 0; i < TO+2; i++) tick();

      @(negedge clk); @(negedge clk);
      chk("R3", sb.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule